// File: doc/BRIEF.md
# Latency-Slotted Result Writeback Queue

This block schedules register writeback for an in-order, statically scheduled microcoded datapath. Each clock cycle one instruction issues. It arrives as a 4-bit opcode, the precomputed result of that operation and a destination field. Every opcode has a fixed latency. The block parks each result in a circular queue of slots, at an offset that the latency sets. Later instructions carry the result out when it matures.

The destination field of the instruction that issues in a cycle does not name where that instruction's own result goes. It names the register that receives the value retiring from the queue head in that same cycle. The microcode compiler therefore places each destination in the instruction that issues exactly when the value matures. A destination of zero discards the retiring value.

The vector-output opcode ends the program. It leaves the queue completely untouched and raises an end-of-program pulse. All outputs are registered and appear one cycle after the issuing edge.

Top module: `wbq_writeback`

## Requirements
- R1: A synchronous active-high reset clears every slot and the head. Both `wb_en` and `prog_end` read 0 after reset. Values popped before any insert are zero.
- R2: Opcodes are 4 bits wide. The codes are: 0 no-op, 1 add, 2 subtract, 3 multiply, 4 absolute value, 5 float-to-int, 6 int-to-float, 7 vector output, 8 sine, 9 cosine, 10 compare-greater, 11 compare-equal, 12 copy, 13 select, 14 sign-transfer, 15 inverse-square-root estimate.
- R3: Latencies are 5 for add and subtract, 7 for multiply, 3 for int-to-float, 4 for sine and cosine, and 2 for every other computing opcode. Count only the queue-advancing instructions (every opcode except 7). A result issued as instruction n is popped by instruction n+L.
- R4: One cycle after an instruction other than opcode 7 issues, the outputs depend on its destination field. If the field is nonzero, `wb_en` is 1, `wb_addr` equals that field and `wb_data` equals the head slot's content. If the field is zero, `wb_en` is 0, so register 0 is never written.
- R5: A slot is cleared when it is popped. A value that was discarded with destination 0 reads as zero one full lap (7 advances) later.
- R6: A no-op pops the head and advances it, but inserts nothing into the queue.
- R7: Opcode 7 does not pop, clear, advance or insert. It produces no writeback. `prog_end` is 1 in the following cycle only.
- R8: A multiply lands in the slot that its own issue just vacated. It retires at the seventh queue-advancing instruction after it.
- R9: Two results can map to the same slot. When they do, the later-issued one overwrites the earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_op | input | 4 | Opcode of the instruction issued this cycle |
| iss_value | input | 32 | Precomputed result of that instruction |
| iss_dst | input | 7 | Destination for the value retiring this cycle (0 = discard) |
| wb_en | output | 1 | Register write strobe |
| wb_addr | output | 7 | Register written |
| wb_data | output | 32 | Value written |
| prog_end | output | 1 | One-cycle pulse after a vector-output instruction |

## Verification
Directed sequences cover several cases, each one separating one requirement from the others:
- Pops straight after reset show that the queue starts empty.
- Each computing opcode is followed by seven popping no-ops. The cycle in which its value appears separates the latency classes.
- A multiply with a vector-output instruction in its window shows that opcode 7 does not count toward the latency.
- An add followed by a sine shares one slot, so the result shows which of the two writes wins.
- A discarded copy that is popped again a lap later shows that popped slots are cleared.

Seeded random opcodes, values and destinations, including zero destinations and vector outputs, then mix all of these cases.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

  typedef enum logic [3:0] {
    OP_IDLE = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_MUL  = 4'd3,
    OP_ABS  = 4'd4,  OP_F2I  = 4'd5,  OP_I2F  = 4'd6,  OP_EMIT = 4'd7,
    OP_SIN  = 4'd8,  OP_COS  = 4'd9,  OP_GT   = 4'd10, OP_EQ   = 4'd11,
    OP_MOVE = 4'd12, OP_SEL  = 4'd13, OP_SGN  = 4'd14, OP_RSQ  = 4'd15
  } op_e;

  localparam int unsigned MAX_LATENCY = 7;

  // R3: fixed issue-to-retire distance of every computing opcode
  function automatic int unsigned op_latency(input op_e op);
    case (op)
      OP_ADD, OP_SUB: return 5;
      OP_MUL:         return 7;
      OP_I2F:         return 3;
      OP_SIN, OP_COS: return 4;
      default:        return 2;
    endcase
  endfunction

endpackage

// File: rtl/wbq_decode.sv
module wbq_decode
  import wbq_pkg::*;
#(
  parameter int LATW = 4
) (
  input  logic [3:0]      op,
  output logic [LATW-1:0] lat,
  output logic            is_emit,
  output logic            is_idle
);
  always_comb begin
    lat     = LATW'(op_latency(op_e'(op)));
    is_emit = (op == OP_EMIT);
    is_idle = (op == OP_IDLE);
  end
endmodule

// File: rtl/wbq_head.sv
module wbq_head #(
  parameter int DEPTH = 7,
  parameter int HW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [HW-1:0] head
);
  localparam logic [HW-1:0] LAST = HW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)      head <= '0;
    else if (adv) head <= (head == LAST) ? '0 : head + 1'b1;
  end
endmodule

// File: rtl/wbq_ring.sv
module wbq_ring #(
  parameter int DEPTH = 7,
  parameter int DW    = 32,
  parameter int HW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] head,
  input  logic          adv,
  input  logic          ins_en,
  input  logic [HW-1:0] ins_idx,
  input  logic [DW-1:0] ins_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[i] <= '0;
      else if (ins_en && ins_idx == HW'(i))   // insert beats clear (R8)
        slot[i] <= ins_data;
      else if (adv && head == HW'(i))         // clear on pop (R5)
        slot[i] <= '0;
    end
  end

  assign rd_data = slot[head];
endmodule

// File: rtl/wbq_writeback.sv
module wbq_writeback
  import wbq_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int DW    = 32,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    iss_op,
  input  logic [DW-1:0] iss_value,
  input  logic [AW-1:0] iss_dst,
  output logic          wb_en,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic          prog_end
);
  localparam int HW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW = HW + 1;
  localparam logic [SW-1:0] DEPTH_W = SW'(DEPTH);

  logic [SW-1:0] lat;
  logic          is_emit, is_idle, adv, ins_en;
  logic [HW-1:0] head_q, ins_idx;
  logic [SW-1:0] sum;
  logic [DW-1:0] head_val;

  wbq_decode #(.LATW(SW)) u_dec (
    .op(iss_op), .lat(lat), .is_emit(is_emit), .is_idle(is_idle)
  );

  assign adv    = !is_emit;
  assign ins_en = adv && !is_idle;

  // slot = (head + 1 + lat - 1) mod DEPTH, with lat <= DEPTH
  always_comb begin
    sum     = {1'b0, head_q} + lat;
    ins_idx = HW'((sum >= DEPTH_W) ? sum - DEPTH_W : sum);
  end

  wbq_head #(.DEPTH(DEPTH), .HW(HW)) u_head (
    .clk(clk), .rst(rst), .adv(adv), .head(head_q)
  );

  wbq_ring #(.DEPTH(DEPTH), .DW(DW), .HW(HW)) u_ring (
    .clk(clk), .rst(rst), .head(head_q), .adv(adv),
    .ins_en(ins_en), .ins_idx(ins_idx), .ins_data(iss_value),
    .rd_data(head_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en    <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
      prog_end <= 1'b0;
    end else begin
      wb_en    <= adv && (iss_dst != '0);
      wb_addr  <= iss_dst;
      wb_data  <= head_val;
      prog_end <= is_emit;
    end
  end
endmodule

// File: rtl/wbq_checker.sv
module wbq_checker #(
  parameter int DEPTH = 7,
  parameter int AW    = 7,
  parameter int HW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    iss_op,
  input logic [AW-1:0] iss_dst,
  input logic          wb_en,
  input logic [AW-1:0] wb_addr,
  input logic          prog_end,
  input logic [HW-1:0] head
);
  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  AST_WB_TARGET: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(iss_op) != 4'd7 && $past(iss_dst) != '0) |-> (wb_en && wb_addr == $past(iss_dst))); // R4
  AST_ZERO_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(iss_dst) == '0) |-> !wb_en); // R4
  AST_EMIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(iss_op) == 4'd7) |-> (!wb_en && prog_end && head == $past(head))); // R7
  AST_EMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(iss_op) != 4'd7) |-> !prog_end); // R7
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(iss_op) != 4'd7) |->
      (head == (($past(head) == HW'(DEPTH - 1)) ? '0 : $past(head) + 1'b1))); // R6
  AST_HEAD_RANGE: assert property (@(posedge clk) disable iff (rst)
    head < HW'(DEPTH)); // R6
endmodule

bind wbq_writeback wbq_checker #(.DEPTH(DEPTH), .AW(AW), .HW(HW)) u_chk (
  .clk(clk), .rst(rst), .iss_op(iss_op), .iss_dst(iss_dst),
  .wb_en(wb_en), .wb_addr(wb_addr), .prog_end(prog_end), .head(head_q)
);

// File: tb/tb_wbq_writeback.sv
module tb_wbq_writeback;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 7;
  localparam int DW = 32;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    iss_op = '0;
  logic [DW-1:0] iss_value = '0;
  logic [AW-1:0] iss_dst = '0;
  logic          wb_en, prog_end;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] m_slot [DEPTH];
  int            m_head = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbq_writeback #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .iss_op(iss_op), .iss_value(iss_value), .iss_dst(iss_dst),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .prog_end(prog_end)
  );

  // R3 latency table, written from the requirement
  function automatic int exp_lat(input logic [3:0] op);
    if (op == 4'd1 || op == 4'd2) return 5;
    if (op == 4'd3) return 7;
    if (op == 4'd6) return 3;
    if (op == 4'd8 || op == 4'd9) return 4;
    return 2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [DW-1:0] val,
                      input logic [AW-1:0] dst, input string tag);
    logic          e_en, e_end;
    logic [DW-1:0] e_data;
    iss_op = op; iss_value = val; iss_dst = dst;
    e_data = '0;
    if (op == 4'd7) begin
      e_en = 1'b0; e_end = 1'b1;
    end else begin
      e_end  = 1'b0;
      e_en   = (dst != '0);
      e_data = m_slot[m_head];
      m_slot[m_head] = '0;
      m_head = (m_head + 1) % DEPTH;
      if (op != 4'd0) m_slot[(m_head + exp_lat(op) - 1) % DEPTH] = val;
    end
    @(posedge clk); @(negedge clk);
    chk({tag, " wb_en"}, 32'(wb_en), 32'(e_en));
    chk({tag, " prog_end"}, 32'(prog_end), 32'(e_end));
    if (e_en) begin
      chk({tag, " wb_addr"}, 32'(wb_addr), 32'(dst));
      chk({tag, " wb_data"}, wb_data, e_data);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_slot[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs after reset, then an empty queue
    chk("R1 reset wb_en", 32'(wb_en), 32'd0);
    chk("R1 reset prog_end", 32'(prog_end), 32'd0);
    for (int i = 1; i <= DEPTH; i++) step(4'd0, 32'hFFFF_FFFF, AW'(i), "R1 empty pop");

    // R3 / R2: every computing opcode followed by seven popping no-ops
    for (int op = 1; op < 16; op++) begin
      if (op == 7) continue;
      step(4'(op), 32'hA000_0000 + 32'(op), 7'd0, "R3 issue");
      for (int k = 1; k <= DEPTH; k++) step(4'd0, 32'h0, AW'(k + 10), "R3 retire");
    end

    // R8: multiply retires at the seventh advancing instruction
    step(4'd3, 32'h1234_5678, 7'd0, "R8 issue");
    for (int k = 1; k < DEPTH; k++) step(4'd0, 32'h0, 7'd3, "R8 early");
    step(4'd0, 32'h0, 7'd9, "R8 retire");

    // R7: emit inside the multiply window does not count
    step(4'd3, 32'hCAFE_0007, 7'd0, "R7 issue");
    step(4'd7, 32'hDEAD_DEAD, 7'd5, "R7 emit");
    step(4'd7, 32'hDEAD_DEAD, 7'd6, "R7 emit twice");
    for (int k = 1; k <= DEPTH; k++) step(4'd0, 32'h0, 7'd4, "R7 after emit");

    // R9: add (5) then sine (4) collide; later one wins
    step(4'd1, 32'h0000_00AD, 7'd0, "R9 add");
    step(4'd8, 32'h0000_051A, 7'd0, "R9 sin");
    for (int k = 1; k <= DEPTH; k++) step(4'd0, 32'h0, 7'd12, "R9 pop");

    // R5: copy discarded with dst 0, same slot read a lap later is zero
    step(4'd12, 32'h5555_AAAA, 7'd0, "R5 copy");
    step(4'd0, 32'h0, 7'd0, "R5 wait");
    step(4'd0, 32'h0, 7'd0, "R5 discard");
    for (int k = 1; k < DEPTH; k++) step(4'd0, 32'h0, 7'd0, "R5 lap");
    step(4'd0, 32'h0, 7'd21, "R5 cleared");

    // R6: no-ops with nonzero value insert nothing
    for (int k = 0; k < 2 * DEPTH; k++) step(4'd0, 32'h7777_7777, 7'd2, "R6 idle");

    // random mix: R2 R3 R4 R7
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 600; n++) begin
      logic [3:0]    rop;
      logic [AW-1:0] rdst;
      rop  = 4'($urandom_range(0, 15));
      rdst = ($urandom_range(0, 3) == 0) ? '0 : AW'($urandom_range(1, 127));
      step(rop, $urandom(), rdst, "R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule